// File: doc/BRIEF.md
# Cycle-Stealing Single-Channel DMA Engine

This block moves a block of words between one peripheral and main memory without the processor copying each word. Software first programs a device address, a starting memory address and a word count through a small register port. It then writes a control word that selects the direction and starts the engine. From that point the engine works on its own. For each word it first handshakes with the device. It then raises a bus request and waits for the grant, and it uses the system bus for exactly one memory cycle. Right after that cycle it drops the request, so the processor loses the bus only for the stolen cycle and keeps its own context.

Device data goes straight to memory, or memory data goes straight to the device, so each word crosses the system bus once. The memory address steps up by one and the remaining count steps down after every word. When the count reaches zero, a completion interrupt is raised. Reading the status register clears that interrupt.

Top module: `dmaEngine`

## Requirements
- R1: After reset `busReq`, `memEn`, `devAck` and `irq` are low, and the status register at offset 0 reads zero.
- R2: While idle, writes to offset 1 (device address), 2 (memory address) and 3 (word count) are stored and read back at the same offsets, and the device address appears on `devAddr`. The status register at offset 0 reads done in bit 2, busy in bit 1 and direction in bit 0.
- R3: Writing offset 0 with bit 0 set starts a transfer. Bit 1 of the same write selects the direction (0 = device to memory, 1 = memory to device). Status busy then reads 1 until the block ends.
- R4: Device to memory: the engine waits for `devReady`, takes `devRdata` in the cycle it pulses `devAck`, and only afterwards raises `busReq`.
- R5: `busReq` stays high until `busGrant` is seen. The single memory cycle (`memEn` high) follows in the next cycle, and `busReq` is low in the cycle after it, so there is one word per grant.
- R6: Memory to device: after `devReady` and a grant, the engine reads `memRdata` during its memory cycle (`memWe` low). In the following cycle it pulses `devAck` with that word on `devWdata`.
- R7: The memory address rises by one after each word and the count falls by one. At the end, offset 2 reads start plus length and offset 3 reads zero.
- R8: Once the last word is moved, busy drops and `irq` rises in the same cycle. `irq` then stays high until the status register is read, and exactly the programmed number of words is moved.
- R9: A status read returns done = 1 and clears done and `irq`, so a second read returns done = 0.
- R10: While busy, writes to any register are ignored, including a second start and a direction change.
- R11: A start with a count of zero sets done and `irq` at once and never raises `busReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (a status read clears done) |
| regAddr | input | 2 | Register offset |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| busReq | output | 1 | System bus request |
| busGrant | input | 1 | System bus grant |
| memEn | output | 1 | Memory cycle strobe |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, valid in the memory cycle |
| devAddr | output | DEV_W | Programmed device address |
| devReady | input | 1 | Device has a word, or can accept one |
| devRdata | input | DATA_W | Word from the device |
| devAck | output | 1 | Word taken from, or delivered to, the device |
| devWdata | output | DATA_W | Word to the device |

## Verification
Four patterns are used for the transfer itself.
- A device-to-memory block with the device always ready and a one-cycle grant shows the basic ordering of handshake, request, grant and memory cycle.
- A second block with the device ready only on alternate cycles and a longer grant delay separates waiting for the device from waiting for the bus.
- A memory-to-device block shows that the read data reaches the device in the cycle after the stolen cycle, in address order.
- A zero-length start shows that completion can occur without any bus activity.

Register writes made during the first block show whether the engine is isolated from software once started.

// File: rtl/dmaPkg.sv
package dmaPkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_DEV,
    S_REQ,
    S_MEM,
    S_PUSH
  } dmaState_t;

  typedef struct packed {
    logic captureDev;
    logic captureMem;
    logic step;
    logic setDone;
  } dmaStrobe_t;
endpackage

// File: rtl/dmaPath.sv
module dmaPath
  import dmaPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int DEV_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              busy,
  input  dmaStrobe_t        strobe,
  input  logic [DATA_W-1:0] devRdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              startReq,
  output logic              dirToDev,
  output logic [DEV_W-1:0]  devAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              countZero,
  output logic              lastWord,
  output logic [DATA_W-1:0] bufData,
  output logic              irq
);
  localparam logic [1:0] OFF_CTRL = 2'd0;
  localparam logic [1:0] OFF_DEV  = 2'd1;
  localparam logic [1:0] OFF_MEM  = 2'd2;
  localparam logic [1:0] OFF_CNT  = 2'd3;

  logic [CNT_W-1:0] countReg;
  logic             doneFlag;
  logic             cfgWrite;

  assign cfgWrite  = regWe && !busy;
  assign startReq  = cfgWrite && (regAddr == OFF_CTRL) && regWdata[0];
  assign countZero = (countReg == '0);
  assign lastWord  = (countReg == CNT_W'(1));
  assign irq       = doneFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirToDev <= 1'b0;
      devAddr  <= '0;
      memAddr  <= '0;
      countReg <= '0;
    end else if (strobe.step) begin
      memAddr  <= memAddr + ADDR_W'(1);
      countReg <= countReg - CNT_W'(1);
    end else if (cfgWrite) begin
      case (regAddr)
        OFF_CTRL: if (regWdata[0]) dirToDev <= regWdata[1];
        OFF_DEV:  devAddr  <= regWdata[DEV_W-1:0];
        OFF_MEM:  memAddr  <= regWdata[ADDR_W-1:0];
        default:  countReg <= regWdata[CNT_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufData <= '0;
    end else if (strobe.captureDev) begin
      bufData <= devRdata;
    end else if (strobe.captureMem) begin
      bufData <= memRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
    end else if (strobe.setDone) begin
      doneFlag <= 1'b1;
    end else if (regRe && regAddr == OFF_CTRL) begin
      doneFlag <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFF_CTRL: regRdata[2:0] = {doneFlag, busy, dirToDev};
      OFF_DEV:  regRdata = DATA_W'(devAddr);
      OFF_MEM:  regRdata = DATA_W'(memAddr);
      default:  regRdata = DATA_W'(countReg);
    endcase
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> memAddr == $past(memAddr) + ADDR_W'(1)); // R7

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(dirToDev) && $stable(devAddr)); // R10

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    irq && !(regRe && regAddr == OFF_CTRL) |=> irq); // R8
endmodule

// File: rtl/dmaCtrl.sv
module dmaCtrl
  import dmaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       countZero,
  input  logic       lastWord,
  input  logic       dirToDev,
  input  logic       devReady,
  input  logic       busGrant,
  output logic       busy,
  output logic       busReq,
  output logic       memEn,
  output logic       memWe,
  output logic       devAck,
  output dmaStrobe_t strobe
);
  dmaState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    busReq    = 1'b0;
    memEn     = 1'b0;
    memWe     = 1'b0;
    devAck    = 1'b0;
    case (state)
      S_IDLE: begin
        if (startReq) begin
          if (countZero) strobe.setDone = 1'b1;
          else           stateNext = S_WAIT_DEV;
        end
      end
      S_WAIT_DEV: begin
        if (devReady) begin
          if (!dirToDev) begin
            strobe.captureDev = 1'b1;
            devAck = 1'b1;
          end
          stateNext = S_REQ;
        end
      end
      S_REQ: begin
        busReq = 1'b1;
        if (busGrant) stateNext = S_MEM;
      end
      S_MEM: begin
        busReq = 1'b1;
        memEn  = 1'b1;
        memWe  = !dirToDev;
        strobe.step = 1'b1;
        strobe.captureMem = dirToDev;
        if (dirToDev) begin
          stateNext = S_PUSH;
        end else if (lastWord) begin
          strobe.setDone = 1'b1;
          stateNext = S_IDLE;
        end else begin
          stateNext = S_WAIT_DEV;
        end
      end
      S_PUSH: begin
        devAck = 1'b1;
        if (countZero) begin
          strobe.setDone = 1'b1;
          stateNext = S_IDLE;
        end else begin
          stateNext = S_WAIT_DEV;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  AST_REQ_UNTIL_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busGrant |=> busReq); // R5

  AST_MEM_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> $past(busReq && busGrant)); // R5

  AST_ONE_WORD: assert property (@(posedge clk) disable iff (!rstN)
    memEn |=> !busReq && !memEn); // R5

  AST_ACK_BEFORE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) && !dirToDev |-> $past(devAck)); // R4

  AST_EMPTY_NO_BUS: assert property (@(posedge clk) disable iff (!rstN)
    startReq && countZero && !busy |=> !busReq && !busy); // R11
endmodule

// File: rtl/dmaEngine.sv
module dmaEngine
  import dmaPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int DEV_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  output logic              busReq,
  input  logic              busGrant,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DEV_W-1:0]  devAddr,
  input  logic              devReady,
  input  logic [DATA_W-1:0] devRdata,
  output logic              devAck,
  output logic [DATA_W-1:0] devWdata
);
  dmaStrobe_t        strobe;
  logic              busy;
  logic              startReq;
  logic              dirToDev;
  logic              countZero;
  logic              lastWord;
  logic [DATA_W-1:0] bufData;

  dmaCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .countZero (countZero),
    .lastWord  (lastWord),
    .dirToDev  (dirToDev),
    .devReady  (devReady),
    .busGrant  (busGrant),
    .busy      (busy),
    .busReq    (busReq),
    .memEn     (memEn),
    .memWe     (memWe),
    .devAck    (devAck),
    .strobe    (strobe)
  );

  dmaPath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .DEV_W  (DEV_W),
    .CNT_W  (CNT_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .regWe     (regWe),
    .regRe     (regRe),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .busy      (busy),
    .strobe    (strobe),
    .devRdata  (devRdata),
    .memRdata  (memRdata),
    .startReq  (startReq),
    .dirToDev  (dirToDev),
    .devAddr   (devAddr),
    .memAddr   (memAddr),
    .countZero (countZero),
    .lastWord  (lastWord),
    .bufData   (bufData),
    .irq       (irq)
  );

  assign memWdata = bufData;
  assign devWdata = bufData;
endmodule

// File: tb/tb_dmaEngine.sv
module tb_dmaEngine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic        regRe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        irq, busReq, memEn, memWe, devAck;
  logic        busGrant;
  logic [15:0] memAddr, memWdata, memRdata, devRdata, devWdata;
  logic [7:0]  devAddr;
  logic        devReady;

  int checks = 0;
  int errors = 0;
  int grantDelay = 0;
  int gcnt = 0;
  bit stallDev = 1'b0;
  bit toDevMode = 1'b0;
  bit sawReq = 1'b0;
  bit prevMemEn = 1'b0;
  bit prevReqGrant = 1'b0;
  bit finished = 1'b0;
  logic [15:0] devIdx = '0;
  logic [31:0] expMemQ[$];
  logic [15:0] expDevQ[$];

  always #10 clk = ~clk;

  dmaEngine dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .busReq(busReq),
    .busGrant(busGrant), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .devAddr(devAddr),
    .devReady(devReady), .devRdata(devRdata), .devAck(devAck), .devWdata(devWdata)
  );

  function automatic logic [15:0] memPattern(logic [15:0] a);
    return a ^ 16'h5A5A;
  endfunction

  assign memRdata = memPattern(memAddr);
  assign devRdata = 16'h1000 + devIdx;

  // bus arbiter and device models
  always @(posedge clk) begin
    if (!rstN || !busReq) begin
      busGrant <= 1'b0;
      gcnt <= 0;
    end else if (gcnt >= grantDelay) begin
      busGrant <= 1'b1;
    end else begin
      gcnt <= gcnt + 1;
    end
    if (!rstN) devReady <= 1'b0;
    else if (stallDev) devReady <= ~devReady;
    else devReady <= 1'b1;
    if (rstN && devAck) devIdx <= devIdx + 16'd1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (busReq) sawReq = 1'b1;
      if (memEn && memWe) begin
        if (expMemQ.size() == 0) check(1'b0, "R8 extra memory write", {memAddr, memWdata}, 32'h0);
        else begin
          logic [31:0] e;
          e = expMemQ.pop_front();
          check({memAddr, memWdata} == e, "R4/R7 memory write", {memAddr, memWdata}, e);
        end
      end
      if (devAck && toDevMode) begin
        if (expDevQ.size() == 0) check(1'b0, "R8 extra device word", {16'h0, devWdata}, 32'h0);
        else begin
          logic [15:0] d;
          d = expDevQ.pop_front();
          check(devWdata == d, "R6 device word", {16'h0, devWdata}, {16'h0, d});
        end
      end
      if (memEn) check(prevReqGrant, "R5 memory cycle after grant", {31'h0, prevReqGrant}, 32'h1);
      if (prevMemEn) check(!busReq, "R5 request dropped after word", {31'h0, busReq}, 32'h0);
      prevMemEn = memEn;
      prevReqGrant = busReq && busGrant;
    end
  end

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regRe = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic waitIrq();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) break;
    end
    check(irq, "R8 completion interrupt", {31'h0, irq}, 32'h1);
  endtask

  task automatic runJob(input bit dir, input logic [15:0] mem, input logic [15:0] cnt, input bit poke);
    logic [15:0] v;
    writeReg(2'd2, mem);
    writeReg(2'd3, cnt);
    for (int i = 0; i < cnt; i++) begin
      if (dir) expDevQ.push_back(memPattern(mem + 16'(i)));
      else expMemQ.push_back({mem + 16'(i), 16'h1000 + devIdx + 16'(i)});
    end
    toDevMode = dir;
    writeReg(2'd0, {14'h0, dir, 1'b1});
    readReg(2'd0, v);
    check(v[1] == 1'b1 && v[0] == dir, "R3 busy after start", {16'h0, v}, {29'h0, 1'b0, 1'b1, dir});
    if (poke) begin
      writeReg(2'd3, 16'd99);
      writeReg(2'd0, 16'h0003);
      writeReg(2'd1, 16'h00EE);
      check(devAddr == 8'h2A, "R10 device address frozen", {24'h0, devAddr}, 32'h2A);
    end
    waitIrq();
    check(expMemQ.size() == 0 && expDevQ.size() == 0, "R8 all words moved",
          expMemQ.size() + expDevQ.size(), 32'h0);
    readReg(2'd0, v);
    check(v[2:0] == {2'b10, dir}, "R8/R9 status done", {16'h0, v}, {29'h0, 2'b10, dir});
    readReg(2'd0, v);
    check(v[2:0] == {2'b00, dir}, "R9 done cleared", {16'h0, v}, {29'h0, 2'b00, dir});
    check(!irq, "R9 irq cleared", {31'h0, irq}, 32'h0);
    readReg(2'd2, v);
    check(v == mem + cnt, "R7 final memory address", {16'h0, v}, {16'h0, mem + cnt});
    readReg(2'd3, v);
    check(v == 16'h0, "R7 final count", {16'h0, v}, 32'h0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busReq && !memEn && !devAck && !irq, "R1 reset outputs",
          {28'h0, busReq, memEn, devAck, irq}, 32'h0);
    rstN = 1'b1;
    readReg(2'd0, v);
    check(v == 16'h0, "R1 status after reset", {16'h0, v}, 32'h0);

    // R2 configuration readback
    writeReg(2'd1, 16'h002A);
    writeReg(2'd2, 16'h0100);
    writeReg(2'd3, 16'h0004);
    readReg(2'd1, v);
    check(v == 16'h002A, "R2 device address readback", {16'h0, v}, 32'h2A);
    check(devAddr == 8'h2A, "R2 device address pin", {24'h0, devAddr}, 32'h2A);
    readReg(2'd2, v);
    check(v == 16'h0100, "R2 memory address readback", {16'h0, v}, 32'h100);
    readReg(2'd3, v);
    check(v == 16'h0004, "R2 count readback", {16'h0, v}, 32'h4);

    // R4 R5 R10: device to memory, register pokes while busy
    grantDelay = 0;
    runJob(1'b0, 16'h0100, 16'd4, 1'b1);

    // R4 R5: stalled device and slow grant
    stallDev = 1'b1;
    grantDelay = 3;
    runJob(1'b0, 16'h0200, 16'd3, 1'b0);

    // R6: memory to device
    stallDev = 1'b0;
    grantDelay = 1;
    runJob(1'b1, 16'h0300, 16'd3, 1'b0);

    // R11: zero-length start
    toDevMode = 1'b0;
    writeReg(2'd3, 16'h0000);
    sawReq = 1'b0;
    writeReg(2'd0, 16'h0001);
    check(irq, "R11 immediate done", {31'h0, irq}, 32'h1);
    repeat (5) @(negedge clk);
    check(!sawReq, "R11 no bus request", {31'h0, sawReq}, 32'h0);
    readReg(2'd0, v);
    check(v[2:0] == 3'b100, "R11 status done idle", {16'h0, v}, 32'h4);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule